// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port with Collision Detection

This block moves one byte at a time over a three-wire synchronous link (clock, data out, data in) and is controlled from a small processor bus through three registers: control, status and data. With the port enabled and set as clock master, writing the data register starts a transfer, and the port drives the serial clock at a fixed fraction of the bus clock. As a slave, the port follows a serial clock supplied by the link partner. The data lines behave the same way in both roles.

Two status flags report what happened. The completion flag is set when the last bit of a byte has been sampled. The collision flag is set when software touches the data register while a byte is still on the wire. Both flags are cleared by a two-step sequence: read the status register while the completion flag is set, then access the data register. A collision raised during a transfer that never completed cannot be cleared that way. Software must disable and re-enable the port to clear it.

Top module: `sio_port`

## Requirements
- R1: After reset the control and status registers read as zero, the port is a slave, `sck_oe` is low and `sck_out` is high.
- R2: Control register bit 0 enables the port and bit 1 selects master. Either bit can be written without the other, and `sck_oe` is high only when both are set.
- R3: In master mode with the port enabled and idle, a data-register write starts a transfer of eight `sck_out` periods of `SCK_DIV` (default 4) bus clocks each. `sck_out` idles high, falls first, and returns high afterwards.
- R4: Data is sent MSB first. `sdo` changes after each falling serial-clock edge and `sdi` is sampled at each rising edge. After the byte, the data register reads the received byte.
- R5: In slave mode the same shifting runs from the synchronised `sck_in`, and `sck_oe` stays low.
- R6: The status register (address 1) holds the collision flag in bit 7 and the completion flag in bit 0. Bits 6 to 1 read as zero.
- R7: The completion flag sets at the final rising edge of every byte. A set flag does not block the next transfer.
- R8: A status read that sees the completion flag set, followed by a data-register read or write, clears both flags. A data access with no preceding armed status read clears nothing.
- R9: A data-register access made after the first falling edge of a byte and before that byte completes sets the collision flag. A write made then does not alter the byte being shifted.
- R10: While the collision flag is set and the completion flag is clear, the clearing sequence has no effect. Writing enable to 0 clears the collision flag.
- R11: Clearing the master bit during a master transfer aborts it: `sck_out` returns high and the completion flag does not set.
- R12: With enable at 0, a data-register write loads the data register but starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register (combinational) |
| sck_in | input | 1 | Serial clock from the link partner (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for `sck_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that a bus read and a bus write are never asserted in the same cycle. They also assume that `sck_in` is held high whenever the port is master, and that in slave mode each level of `sck_in` lasts several bus clocks, so that every edge survives the synchroniser. The bench drives every bus access as a single-cycle strobe. It keeps its own clock line idle high except inside slave bytes, and it holds each slave clock level for four bus clocks. A link-partner model in the bench changes `sdi` on the falling edge of whichever clock is live and captures `sdo` on the rising edge, so the received bytes it reports are checked against the sent bytes at the pins.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_MST_BIT  = 1;
   localparam int unsigned STAT_DONE_BIT = 0;
   localparam int unsigned STAT_COLL_BIT = 7;
endpackage

// File: rtl/sio_sck_gen.sv
// Serial clock source: divider in master mode, synchroniser and edge
// detector in slave mode. Emits single-cycle fall/rise events.
module sio_sck_gen #(
   parameter int unsigned DIV         = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spe,
   input  logic mstr,
   input  logic run_m,
   input  logic sck_in,
   output logic sck_out,
   output logic fall_evt,
   output logic rise_evt
);
   localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int unsigned HALF  = DIV / 2;
   localparam logic [DIV_W-1:0] HALF_V = DIV_W'(HALF);
   localparam logic [DIV_W-1:0] LAST_V = DIV_W'(DIV - 1);

   logic [DIV_W-1:0] phase;
   logic             sck_q;
   logic             m_fall, m_rise;
   logic             sck_sync, sck_prev;
   logic             s_fall, s_rise, slave_ok;

   assign m_fall = run_m && (phase == '0);
   assign m_rise = run_m && (phase == HALF_V);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_m) begin
         phase <= '0;
         sck_q <= 1'b1;
      end else begin
         phase <= (phase == LAST_V) ? '0 : phase + 1'b1;
         if (m_fall)      sck_q <= 1'b0;
         else if (m_rise) sck_q <= 1'b1;
      end
   end

   generate
      if (SYNC_STAGES < 2) begin : g_sync_one
         always_ff @(posedge clk) begin
            if (!rst_n) sck_sync <= 1'b1;
            else        sck_sync <= sck_in;
         end
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], sck_in};
         end
         assign sck_sync = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sck_prev <= 1'b1;
      else        sck_prev <= sck_sync;
   end

   assign slave_ok = spe && !mstr;
   assign s_fall   = slave_ok &&  sck_prev && !sck_sync;
   assign s_rise   = slave_ok && !sck_prev &&  sck_sync;

   assign fall_evt = mstr ? m_fall : s_fall;
   assign rise_evt = mstr ? m_rise : s_rise;
   assign sck_out  = sck_q;
endmodule

// File: rtl/sio_shift.sv
// Shift register, bit counter and transfer state.
module sio_shift #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spe,
   input  logic              mstr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              fall_evt,
   input  logic              rise_evt,
   input  logic              sdi,
   output logic [DATA_W-1:0] shreg,
   output logic              busy,
   output logic              xfer_m,
   output logic              active,
   output logic              done,
   output logic              sdo
);
   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] bit_cnt;
   logic             abort, load_ok;

   assign abort   = !spe || (busy && (xfer_m != mstr));
   assign load_ok = load && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         busy    <= 1'b0;
         xfer_m  <= 1'b0;
         active  <= 1'b0;
         done    <= 1'b0;
         sdo     <= 1'b0;
         bit_cnt <= '0;
      end else begin
         done <= 1'b0;
         if (load_ok) shreg <= load_data;
         if (abort) begin
            busy    <= 1'b0;
            active  <= 1'b0;
            bit_cnt <= '0;
         end else if (load_ok && mstr) begin
            busy    <= 1'b1;
            xfer_m  <= 1'b1;
            active  <= 1'b0;
            bit_cnt <= '0;
         end else if (!busy && fall_evt) begin
            busy    <= 1'b1;
            xfer_m  <= 1'b0;
            active  <= 1'b1;
            bit_cnt <= '0;
            sdo     <= shreg[DATA_W-1];
         end else if (busy) begin
            if (fall_evt) begin
               active <= 1'b1;
               sdo    <= shreg[DATA_W-1];
            end
            if (rise_evt) begin
               shreg <= {shreg[DATA_W-2:0], sdi};
               if (bit_cnt == LAST_BIT) begin
                  busy    <= 1'b0;
                  active  <= 1'b0;
                  bit_cnt <= '0;
                  done    <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sio_flags.sv
// Completion and collision flags with the armed-clear latch.
module sio_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic spe,
   input  logic stat_rd,
   input  logic data_acc,
   input  logic active,
   input  logic done,
   output logic spif,
   output logic dcol
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         spif  <= 1'b0;
         dcol  <= 1'b0;
      end else begin
         if (data_acc)             armed <= 1'b0;
         else if (stat_rd && spif) armed <= 1'b1;

         if (done)                   spif <= 1'b1;
         else if (data_acc && armed) spif <= 1'b0;

         if (!spe)                   dcol <= 1'b0;
         else if (data_acc && active) dcol <= 1'b1;
         else if (data_acc && armed)  dcol <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_port.sv
module sio_port
   import sio_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SCK_DIV     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              sdi,
   output logic              sdo
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("sio_port: DATA_W must be at least 8");
      end
      if (SCK_DIV < 2 || (SCK_DIV % 2) != 0) begin : g_bad_div
         $error("sio_port: SCK_DIV must be even and at least 2");
      end
   endgenerate

   reg_sel_e          sel;
   logic              spe_q, mstr_q;
   logic              stat_rd, data_acc, data_wr;
   logic              fall_evt, rise_evt, run_m;
   logic [DATA_W-1:0] shreg;
   logic              busy, xfer_m, active, done;
   logic              spif, dcol;

   assign sel      = reg_sel_e'(bus_addr);
   assign stat_rd  = bus_rd && (sel == REG_STAT);
   assign data_wr  = bus_wr && (sel == REG_DATA);
   assign data_acc = (bus_wr || bus_rd) && (sel == REG_DATA);
   assign run_m    = busy && xfer_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spe_q  <= 1'b0;
         mstr_q <= 1'b0;
      end else if (bus_wr && sel == REG_CTRL) begin
         spe_q  <= bus_wdata[CTRL_EN_BIT];
         mstr_q <= bus_wdata[CTRL_MST_BIT];
      end
   end

   sio_sck_gen #(.DIV(SCK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_sck (
      .clk      (clk),
      .rst_n    (rst_n),
      .spe      (spe_q),
      .mstr     (mstr_q),
      .run_m    (run_m),
      .sck_in   (sck_in),
      .sck_out  (sck_out),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt)
   );

   sio_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .spe       (spe_q),
      .mstr      (mstr_q),
      .load      (data_wr),
      .load_data (bus_wdata),
      .fall_evt  (fall_evt),
      .rise_evt  (rise_evt),
      .sdi       (sdi),
      .shreg     (shreg),
      .busy      (busy),
      .xfer_m    (xfer_m),
      .active    (active),
      .done      (done),
      .sdo       (sdo)
   );

   sio_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .spe      (spe_q),
      .stat_rd  (stat_rd),
      .data_acc (data_acc),
      .active   (active),
      .done     (done),
      .spif     (spif),
      .dcol     (dcol)
   );

   assign sck_oe = spe_q && mstr_q;

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         REG_CTRL: begin
            bus_rdata[CTRL_EN_BIT]  = spe_q;
            bus_rdata[CTRL_MST_BIT] = mstr_q;
         end
         REG_STAT: begin
            bus_rdata[STAT_COLL_BIT] = dcol;
            bus_rdata[STAT_DONE_BIT] = spif;
         end
         REG_DATA: bus_rdata = shreg;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              sck_out,
   input logic              spe,
   input logic              mstr,
   input logic              busy,
   input logic              xfer_m,
   input logic              done,
   input logic              data_acc,
   input logic              spif,
   input logic              dcol
);
   // R6
   stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd1) |-> (bus_rdata[6:1] == 6'd0));

   // R7
   spif_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> spif);

   // R8
   spif_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spif) |-> $past(data_acc));

   // R10
   dcol_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dcol && !spif && spe) |=> dcol);

   // R11
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_m && !mstr) |=> !busy);

   // R3
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> sck_out);

   // R3
   sck_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sck_out) && mstr && spe) |=> !sck_out);
endmodule

bind sio_port sio_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .sck_out   (sck_out),
   .spe       (spe_q),
   .mstr      (mstr_q),
   .busy      (busy),
   .xfer_m    (xfer_m),
   .done      (done),
   .data_acc  (data_acc),
   .spif      (spif),
   .dcol      (dcol)
);

// File: tb/sio_port_tb.sv
`timescale 1ns/1ps
module sio_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sck_drv = 1'b1;
   logic       sck_out, sck_oe;
   logic       sdi = 1'b0;
   logic       sdo;
   logic       sck_line;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int fall_cnt = 0, fall_base = 0;
   int last_fall = 0, prev_fall = 0;
   logic [7:0] peer_tx = 8'h00;
   logic [7:0] peer_rx = 8'h00;

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   sio_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_in(sck_drv), .sck_out(sck_out), .sck_oe(sck_oe),
      .sdi(sdi), .sdo(sdo)
   );

   assign sck_line = sck_oe ? sck_out : sck_drv;

   // link partner: drive on falling edge, capture on rising edge
   always @(negedge sck_line) begin
      if ((fall_cnt - fall_base) < 8)
         sdi = peer_tx[7 - (fall_cnt - fall_base)];
      fall_cnt++;
      prev_fall = last_fall;
      last_fall = cyc;
   end
   always @(posedge sck_line) peer_rx = {peer_rx[6:0], sdo};

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peer_set(input logic [7:0] tx);
      peer_tx = tx;
      fall_base = fall_cnt;
   endtask

   task automatic slave_byte();
      for (int b = 0; b < 8; b++) begin
         @(negedge clk) sck_drv = 1'b0;
         wait_clk(4);
         @(negedge clk) sck_drv = 1'b1;
         wait_clk(4);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      bus_read(2'd0, v); check("R1 ctrl", v, 8'h00);
      bus_read(2'd1, v); check("R1 status", v, 8'h00);
      check("R1 sck_oe", sck_oe, 0);
      check("R1 sck_out", sck_out, 1);
   endtask

   task automatic t_master_basic();
      logic [7:0] v;
      bus_write(2'd0, 8'h03);
      check("R2 sck_oe", sck_oe, 1);
      peer_set(8'h3C);
      bus_write(2'd2, 8'hA5);
      wait_clk(40);
      check("R3 falling edges", fall_cnt - fall_base, 8);
      check("R3 period", last_fall - prev_fall, 4);
      check("R3 idle high", sck_out, 1);
      check("R4 sdo byte", peer_rx, 8'hA5);
      bus_read(2'd1, v); check("R6 status done", v, 8'h01);
      bus_read(2'd2, v); check("R4 received", v, 8'h3C);
      bus_read(2'd1, v); check("R8 cleared", v, 8'h00);
   endtask

   task automatic t_sticky_and_clear();
      logic [7:0] v;
      peer_set(8'h00);
      bus_write(2'd2, 8'h11);
      wait_clk(40);
      peer_set(8'h00);
      bus_write(2'd2, 8'h22);   // flag set, not armed: transfer still runs
      wait_clk(40);
      check("R7 next transfer", peer_rx, 8'h22);
      bus_read(2'd2, v);
      bus_read(2'd1, v); check("R8 unarmed access", v, 8'h01);
      bus_read(2'd2, v);
      bus_read(2'd1, v); check("R8 armed clear", v, 8'h00);
      bus_read(2'd1, v);
      peer_set(8'h00);
      bus_write(2'd2, 8'h44);
      wait_clk(40);
      bus_read(2'd1, v);          // arm
      bus_write(2'd2, 8'h55);     // clears and starts
      wait_clk(3);
      bus_read(2'd1, v); check("R8 cleared by write", v, 8'h00);
      wait_clk(40);
      bus_read(2'd1, v); check("R7 sets again", v, 8'h01);
      bus_read(2'd2, v);
   endtask

   task automatic t_collision();
      logic [7:0] v;
      peer_set(8'h66);
      bus_write(2'd2, 8'h99);
      wait_clk(10);
      bus_read(2'd2, v);
      bus_read(2'd1, v); check("R9 dcol mid", v, 8'h80);
      bus_write(2'd2, 8'h00);
      wait_clk(40);
      check("R9 write ignored", peer_rx, 8'h99);
      bus_read(2'd1, v); check("R6 both flags", v, 8'h81);
      bus_read(2'd2, v); check("R9 received", v, 8'h66);
      bus_read(2'd1, v); check("R8 both cleared", v, 8'h00);
   endtask

   task automatic t_abort();
      logic [7:0] v;
      peer_set(8'h00);
      bus_write(2'd2, 8'h5A);
      wait_clk(10);
      bus_read(2'd2, v);
      bus_write(2'd0, 8'h01);
      wait_clk(40);
      check("R11 partial byte", (fall_cnt - fall_base) < 8, 1);
      check("R11 sck high", sck_out, 1);
      bus_read(2'd1, v); check("R11 no done", v, 8'h80);
      bus_read(2'd2, v);
      bus_read(2'd1, v); check("R10 dcol stuck", v, 8'h80);
      bus_write(2'd0, 8'h00);
      bus_write(2'd0, 8'h01);
      bus_read(2'd1, v); check("R10 toggle clears", v, 8'h00);
   endtask

   task automatic t_slave();
      logic [7:0] v;
      peer_set(8'h5B);
      bus_write(2'd2, 8'h96);
      slave_byte();
      wait_clk(8);
      check("R5 sck_oe low", sck_oe, 0);
      check("R5 sdo byte", peer_rx, 8'h96);
      bus_read(2'd1, v); check("R5 done", v, 8'h01);
      bus_read(2'd2, v); check("R5 received", v, 8'h5B);
      bus_read(2'd1, v);
      // clearing access lands after the next byte has begun
      peer_set(8'h0F);
      bus_write(2'd2, 8'h00);
      slave_byte();
      wait_clk(8);
      bus_read(2'd1, v);          // arm
      peer_set(8'hC3);
      fork
         slave_byte();
         begin wait_clk(12); bus_read(2'd2, v); end
      join
      wait_clk(8);
      bus_read(2'd1, v); check("R9 dcol set again", v, 8'h81);
      bus_read(2'd2, v); check("R5 second byte", v, 8'hC3);
      bus_read(2'd1, v); check("R8 slave clear", v, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      bus_write(2'd0, 8'h02);
      bus_read(2'd0, v); check("R2 master without enable", v, 8'h02);
      check("R2 sck_oe off", sck_oe, 0);
      peer_set(8'h00);
      bus_write(2'd2, 8'h77);
      wait_clk(40);
      check("R12 no clock", fall_cnt - fall_base, 0);
      bus_read(2'd1, v); check("R12 no done", v, 8'h00);
      bus_read(2'd2, v); check("R12 loaded", v, 8'h77);
   endtask

   initial begin
      fork
         begin
            wait_clk(4);
            @(negedge clk) rst_n = 1'b1;
            wait_clk(2);
            t_reset();
            t_master_basic();
            t_sticky_and_clear();
            t_collision();
            t_abort();
            t_slave();
            t_disabled();
         end
         begin
            wait_clk(150000);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule